// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is a bus master that performs a single read or write transfer, to memory or to I/O space, over a bus where the low address byte and the data byte share eight lines. A requester presents a 16-bit address, a direction flag, a space flag and a write byte. The sequencer first places the low address byte on the shared lines and raises an address strobe so an external latch can hold that byte. It then turns the shared lines over to data and drives an active-low read or write strobe.

Slow targets stretch the transfer through a ready input. Ready is sampled on the falling clock edge in the middle of the first strobe clock. A low sample adds one wait clock, during which every output holds its value, and ready is sampled again on the next falling edge. A high sample lets the cycle finish. A one-clock done pulse closes the transfer and comes with the read byte. A model of the external address latch is built in, so that the full demultiplexed address can be seen on an output.

Top module: `mux_bus_seq`

## Requirements
- R1: After a synchronous active-high reset, and whenever no transfer is running, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0 (shared lines released), `io_sel` is 0, `done` is 0 and `req_ready` is 1. A reset applied in the middle of a transfer returns the block to this state on the next clock edge.
- R2: A request made while idle starts a transfer on the next clock (T1). `ale` is 1 only during the first half of T1. Throughout T1 the shared lines are driven (`ad_oe`=1) with address bits 7:0, and `addr_hi` carries address bits 15:8 from T1 to the last clock of the transfer.
- R3: The latch model captures the shared lines on the falling edge of `ale`. From the first strobe clock to the end of the transfer, `lat_addr` equals the full 16-bit request address.
- R4: When ready is 1 at the falling edge in the middle of the first strobe clock (T2), the strobe stays active for exactly two clocks (T2, T3). `done` is 1 in the clock after T3.
- R5: Each ready sample of 0 inserts exactly one wait clock between T2 and T3, and ready is sampled again on every later falling edge. With w low samples the strobe is active for 2+w clocks.
- R6: During wait clocks, `ad_o`, `ad_oe`, `addr_hi`, `rd_n`, `wr_n` and `io_sel` keep the values they had in T2, and those values also persist into T3.
- R7: In a write (`req_write`=1), `wr_n` is 0 and `rd_n` is 1 on every strobe clock, and the shared lines are driven with the write byte from T2 through the end of T3.
- R8: In a read (`req_write`=0), `rd_n` is 0 and `wr_n` is 1 on every strobe clock, the shared lines are released from T2 onward, and `rdata` holds the value of `ad_i` at the end of T3 while `done` is 1.
- R9: `rd_n` and `wr_n` are never 0 at the same time.
- R10: `done` lasts exactly one clock per transfer. A request presented while a transfer is running is ignored: `req_ready` is 0, the address and direction of the running transfer do not change, and no second transfer follows.
- R11: `io_sel` equals the request's space flag (1 = I/O, 0 = memory) from T1 through T3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; ready and the strobe timing also use its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request a transfer; taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Block is idle and will take a request |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte read, valid while done is 1 after a read |
| ready | input | 1 | Target ready; low stretches the transfer |
| ale | output | 1 | Address latch strobe, high while low address is on the shared lines |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_sel | output | 1 | Space select for the running transfer |
| addr_hi | output | 8 | Dedicated high address lines |
| ad_o | output | 8 | Value driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_i | input | 8 | Value seen on the shared lines when released |
| lat_addr | output | 16 | Demultiplexed address from the latch model and high lines |

## Verification
The risky overlap is a new request arriving in the same clock as a running transfer's wait-state hold. The bench raises `req_valid` with a different address during the first strobe clock of a stretched read. It then judges the result by checking that `req_ready` was low, that `lat_addr`, `addr_hi` and the strobes kept their snapshot through every wait clock, and that only one done pulse follows with no second address strobe. A second overlap, a reset landing on a strobe clock, is judged by checking that the idle outputs appear on the very next clock.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int unsigned MB_AW = 16;
    localparam int unsigned MB_DW = 8;
    localparam int unsigned MB_HW = MB_AW - MB_DW;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_TW   = 3'd3,
        PH_T3   = 3'd4
    } mb_phase_e;

    typedef struct packed {
        logic             write;
        logic             io;
        logic [MB_AW-1:0] addr;
        logic [MB_DW-1:0] wdata;
    } mb_req_t;

    function automatic logic strobe_phase(input mb_phase_e p);
        return (p == PH_T2) || (p == PH_TW) || (p == PH_T3);
    endfunction

    function automatic logic [MB_DW-1:0] addr_low(input logic [MB_AW-1:0] a);
        return a[MB_DW-1:0];
    endfunction

    function automatic logic [MB_HW-1:0] addr_high(input logic [MB_AW-1:0] a);
        return a[MB_AW-1:MB_DW];
    endfunction

endpackage

// File: rtl/mbus_phase_fsm.sv
module mbus_phase_fsm
    import mbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic      rdy_s,
    output logic      accept,
    output mb_phase_e phase,
    output logic      done
);

    mb_phase_e phase_nx;

    assign accept = req_valid && (phase == PH_IDLE);

    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE: if (req_valid) phase_nx = PH_T1;
            PH_T1:   phase_nx = PH_T2;
            PH_T2,
            PH_TW:   phase_nx = rdy_s ? PH_T3 : PH_TW;
            PH_T3:   phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= (phase == PH_T3);
        end
    end

    // R5: a wait clock is only ever entered from T2 or another wait clock
    p_wait_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TW) |-> ($past(phase) == PH_T2 || $past(phase) == PH_TW));

    // R4: a high ready sample in a strobe clock leads straight to T3
    p_ready_ends_r4: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_T2 || phase == PH_TW) && rdy_s) |=> (phase == PH_T3));

    // R10: completion pulse is one clock wide and follows T3
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_src_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(phase) == PH_T3));

endmodule

// File: rtl/mbus_half_stage.sv
module mbus_half_stage
    import mbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ready,
    input  mb_phase_e phase,
    output logic      rdy_s,
    output logic      t1_late
);

    // Falling-edge stage: ready sample and the half-clock marker that ends
    // the address strobe in the middle of T1.
    always_ff @(negedge clk) begin
        if (rst) begin
            rdy_s   <= 1'b0;
            t1_late <= 1'b0;
        end else begin
            rdy_s   <= ready;
            t1_late <= (phase == PH_T1);
        end
    end

endmodule

// File: rtl/mbus_bus_drive.sv
module mbus_bus_drive
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  mb_req_t          req,
    input  mb_phase_e        phase,
    input  logic             t1_late,
    input  logic [MB_DW-1:0] bus_in,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             io_sel,
    output logic [MB_HW-1:0] addr_hi,
    output logic [MB_DW-1:0] ad_o,
    output logic             ad_oe,
    output logic [MB_DW-1:0] rdata
);

    mb_req_t held;
    logic    active;
    logic    stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            rdata <= '0;
        end else begin
            if (accept) begin
                held <= req;
            end
            if (phase == PH_T3 && !held.write) begin
                rdata <= bus_in;
            end
        end
    end

    assign active  = (phase != PH_IDLE);
    assign stb     = strobe_phase(phase);
    assign ale     = (phase == PH_T1) && !t1_late;
    assign addr_hi = active ? addr_high(held.addr) : '0;
    assign io_sel  = active && held.io;
    assign rd_n    = !(stb && !held.write);
    assign wr_n    = !(stb && held.write);
    assign ad_oe   = (phase == PH_T1) || (stb && held.write);

    always_comb begin
        if (phase == PH_T1) begin
            ad_o = addr_low(held.addr);
        end else if (stb && held.write) begin
            ad_o = held.wdata;
        end else begin
            ad_o = '0;
        end
    end

    // R9: strobes are mutually exclusive
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R1: idle keeps the bus quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (rd_n && wr_n && !ad_oe && !io_sel));

    // R6: every bus output holds through a wait clock
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TW) |-> ($stable(ad_o) && $stable(ad_oe) && $stable(addr_hi)
                              && $stable(rd_n) && $stable(wr_n) && $stable(io_sel)));

    // R8: lines are released whenever the read strobe is active
    p_read_float_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    // R7: write strobe always comes with driven lines
    p_write_drive_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    // R10: the captured request cannot change while a transfer runs
    p_held_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(held));

endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
    parameter int unsigned W = 8
) (
    input  logic         ale,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Model of an external byte latch closing on the strobe's falling edge.
    always_ff @(negedge ale) begin
        q <= d;
    end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_io,
    input  logic [MB_AW-1:0] req_addr,
    input  logic [MB_DW-1:0] req_wdata,
    output logic             req_ready,
    output logic             done,
    output logic [MB_DW-1:0] rdata,
    input  logic             ready,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             io_sel,
    output logic [MB_HW-1:0] addr_hi,
    output logic [MB_DW-1:0] ad_o,
    output logic             ad_oe,
    input  logic [MB_DW-1:0] ad_i,
    output logic [MB_AW-1:0] lat_addr
);

    mb_phase_e        phase;
    logic             accept;
    logic             rdy_s;
    logic             t1_late;
    logic [MB_DW-1:0] bus_val;
    logic [MB_DW-1:0] lat_lo;
    mb_req_t          req;

    assign req       = '{write: req_write, io: req_io, addr: req_addr, wdata: req_wdata};
    assign req_ready = (phase == PH_IDLE);
    assign bus_val   = ad_oe ? ad_o : ad_i;
    assign lat_addr  = {addr_hi, lat_lo};

    mbus_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .rdy_s     (rdy_s),
        .accept    (accept),
        .phase     (phase),
        .done      (done)
    );

    mbus_half_stage u_half (
        .clk     (clk),
        .rst     (rst),
        .ready   (ready),
        .phase   (phase),
        .rdy_s   (rdy_s),
        .t1_late (t1_late)
    );

    mbus_bus_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .req     (req),
        .phase   (phase),
        .t1_late (t1_late),
        .bus_in  (bus_val),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .io_sel  (io_sel),
        .addr_hi (addr_hi),
        .ad_o    (ad_o),
        .ad_oe   (ad_oe),
        .rdata   (rdata)
    );

    mbus_addr_latch #(.W(MB_DW)) u_latch (
        .ale (ale),
        .d   (bus_val),
        .q   (lat_lo)
    );

    // R3: latch holds the byte that was on the lines during T1
    p_latch_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T2) |-> (lat_lo == $past(ad_o)));
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TW || phase == PH_T3) |-> $stable(lat_lo));

    // R10: busy means no request is taken
    p_busy_reject_r10: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> !accept);

endmodule

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;

    typedef struct packed {
        logic        wr;
        logic        io;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [7:0]  rb;
        logic [3:0]  waits;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 16'h1234, 8'h00, 8'hA5, 4'd0},
        '{1'b1, 1'b0, 16'hBEEF, 8'h5A, 8'h00, 4'd0},
        '{1'b0, 1'b1, 16'h00FF, 8'h00, 8'h3C, 4'd1},
        '{1'b1, 1'b1, 16'hFF00, 8'hC3, 8'h00, 4'd2},
        '{1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 4'd5},
        '{1'b1, 1'b0, 16'h0000, 8'hFF, 8'h00, 4'd3},
        '{1'b0, 1'b0, 16'h8001, 8'h00, 8'h7E, 4'd0},
        '{1'b1, 1'b0, 16'h55AA, 8'h81, 8'h00, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        done;
    logic [7:0]  rdata;
    logic        ready = 1'b1;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic        io_sel;
    logic [7:0]  addr_hi;
    logic [7:0]  ad_o;
    logic        ad_oe;
    logic [7:0]  ad_i = 8'hEE;
    logic [15:0] lat_addr;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    mux_bus_seq i_mux_bus_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_io    (req_io),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .done      (done),
        .rdata     (rdata),
        .ready     (ready),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .io_sel    (io_sel),
        .addr_hi   (addr_hi),
        .ad_o      (ad_o),
        .ad_oe     (ad_oe),
        .ad_i      (ad_i),
        .lat_addr  (lat_addr)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string rq);
        chk(ale == 1'b0 && rd_n && wr_n && !ad_oe && !io_sel && req_ready && !done, rq,
            {ale, rd_n, wr_n, ad_oe, io_sel, req_ready, done}, 7'b0110010);
    endtask

    // One full transfer; stray=1 injects a request during the first strobe clock.
    task automatic run_vec(input vec_t v, input bit stray);
        int          nstb;
        logic [19:0] snap;
        logic [19:0] cur;
        bit          got_done;
        nstb = 0;
        got_done = 1'b0;
        snap = '0;
        @(posedge clk); #1;
        chk(req_ready, "R1 idle before request", {31'd0, req_ready}, 1);
        req_valid = 1'b1;
        req_write = v.wr;
        req_io    = v.io;
        req_addr  = v.addr;
        req_wdata = v.wd;
        ready     = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        // T1, first half
        chk(ale == 1'b1, "R2 ale high early T1", {31'd0, ale}, 1);
        chk(ad_oe && ad_o == v.addr[7:0], "R2 low address on lines", {23'd0, ad_oe, ad_o}, {23'd0, 1'b1, v.addr[7:0]});
        chk(addr_hi == v.addr[15:8], "R2 high address lines", {24'd0, addr_hi}, {24'd0, v.addr[15:8]});
        chk(io_sel == v.io, "R11 space select in T1", {31'd0, io_sel}, {31'd0, v.io});
        chk(rd_n && wr_n, "R9 no strobe in T1", {30'd0, rd_n, wr_n}, 2'b11);
        #2;
        chk(ale == 1'b0, "R2 ale low late T1", {31'd0, ale}, 0);
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #1;
            if (stray && nstb == 1) begin
                req_valid = 1'b0;
            end
            if (done) begin
                got_done = 1'b1;
                break;
            end
            ready = (nstb >= int'(v.waits));
            ad_i  = !rd_n ? v.rb : 8'hEE;
            cur = {ad_o, ad_oe, addr_hi, rd_n, wr_n, io_sel};
            if (nstb == 0) begin
                snap = cur;
                if (stray) begin
                    chk(!req_ready, "R10 busy while running", {31'd0, req_ready}, 0);
                    req_valid = 1'b1;
                    req_write = ~v.wr;
                    req_addr  = ~v.addr;
                    req_wdata = ~v.wd;
                end
            end else begin
                chk(cur == snap, "R6 outputs held in wait", {12'd0, cur}, {12'd0, snap});
            end
            chk(!(!rd_n && !wr_n), "R9 strobes exclusive", {30'd0, rd_n, wr_n}, 2'b11);
            chk(lat_addr == v.addr, "R3 latched address", {16'd0, lat_addr}, {16'd0, v.addr});
            chk(io_sel == v.io, "R11 space select in strobe", {31'd0, io_sel}, {31'd0, v.io});
            if (v.wr) begin
                chk(!wr_n && rd_n && ad_oe && ad_o == v.wd, "R7 write strobe and data",
                    {21'd0, wr_n, rd_n, ad_oe, ad_o}, {21'd0, 1'b0, 1'b1, 1'b1, v.wd});
            end else begin
                chk(!rd_n && wr_n && !ad_oe, "R8 read strobe and released lines",
                    {29'd0, rd_n, wr_n, ad_oe}, 3'b010);
            end
            nstb++;
        end
        ready = 1'b1;
        ad_i  = 8'hEE;
        req_valid = 1'b0;
        chk(got_done, "R4 done reached", {31'd0, got_done}, 1);
        if (v.waits == 0) begin
            chk(nstb == 2, "R4 strobe length no wait", nstb, 2);
        end else begin
            chk(nstb == 2 + int'(v.waits), "R5 strobe length with waits", nstb, 2 + int'(v.waits));
        end
        if (!v.wr) begin
            chk(rdata == v.rb, "R8 read byte", {24'd0, rdata}, {24'd0, v.rb});
        end
        @(posedge clk); #1;
        chk(!done, "R10 done one clock", {31'd0, done}, 0);
        chk_idle("R1 idle after transfer");
        if (stray) begin
            for (int k = 0; k < 3; k++) begin
                #2;
                chk(!ale && rd_n && wr_n, "R10 no transfer from ignored request",
                    {29'd0, ale, rd_n, wr_n}, 3'b011);
                @(posedge clk); #1;
            end
        end
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_idle("R1 state during reset");
        rst = 1'b0;
        @(posedge clk); #1;
        chk_idle("R1 state after reset");

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], 1'b0);
        end

        // R10: stray request during a stretched read
        run_vec('{1'b0, 1'b0, 16'h2468, 8'h00, 8'h99, 4'd2}, 1'b1);

        // R1: reset landing on a strobe clock
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_write = 1'b1;
        req_io    = 1'b1;
        req_addr  = 16'hA55A;
        req_wdata = 8'h42;
        ready     = 1'b0;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(posedge clk); #1;
        chk(!wr_n, "R7 write strobe before reset", {31'd0, wr_n}, 0);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        ready = 1'b1;
        chk_idle("R1 reset mid transfer");
        @(posedge clk); #1;
        chk(!done, "R10 no done after reset", {31'd0, done}, 0);

        // recovery transfer after the abort
        run_vec('{1'b1, 1'b0, 16'h0F0F, 8'h3C, 8'h00, 4'd1}, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule